// File: doc/BRIEF.md
# Interrupt Control Register with Delayed Summary

This block is the interrupt controller of a small peripheral with five interrupt sources. The sources are timer A, timer B, a time-of-day alarm, a serial port and an edge flag input. Each source delivers a single-cycle pulse. The pulse sets a pending flag, and the flag stays set until software clears it. A mask decides which pending flags may raise the summary bit and the active-low request pin. Software writes the mask with set/clear semantics: bit 7 of the written byte chooses whether the selected bits are set or cleared.

The CPU reads one byte. That byte holds the pending flags and the summary bit. The read clears the flags on the following cycle. A write to the register also clears the flags, but later, two cycles after the write. The summary bit lags the flags by one cycle, both when it sets and when it clears. The request pin follows the summary at cycle boundaries. There is one exception: while a read is in progress, the pin is released at once. When a source fires every cycle, the pin is therefore inactive only for the read cycle.

Top module: `icr_core`

## Requirements
- R1: A pulse on source i sets pending flag i from the next cycle on, whether or not it is masked. Bit positions: timer A = bit 0, timer B = bit 1, alarm = bit 2, serial = bit 3, flag input = bit 4.
- R2: A write with data bit 7 = 1 sets the mask bits given as 1 in data bits 4..0. A write with bit 7 = 0 clears them. The other mask bits keep their values.
- R3: The summary (read bit 7) becomes 1 one cycle after a pending flag whose mask bit is set is first visible. Flags that are masked off never set it.
- R4: The read view is {summary, 2'b00, flags[4:0]}. During the read cycle it shows the flags before the clear. From the next cycle the flags show only events that arrived in the read cycle.
- R5: After the flags clear, the summary clears one cycle later.
- R6: After a write cycle, the pending flags stay visible for two more cycles. From the third cycle they show only new events.
- R7: irq_n is low exactly when the registered request is set. It changes only at clock edges and asserts in the same cycle the summary first reads 1.
- R8: While rd_en is high, irq_n is high in that same cycle.
- R9: If an unmasked source fires every cycle, a read releases irq_n only for the read cycle, and the summary bit stays 1.
- R10: After reset the flags, mask and summary are zero and irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 5 | Single-cycle source pulses, bit order as in R1 |
| rd_en | input | 1 | Register read strobe for this cycle |
| wr_en | input | 1 | Register write strobe for this cycle |
| wr_data | input | 8 | Mask write data, bit 7 selects set/clear |
| rd_data | output | 8 | Register read view {summary, 0, 0, flags} |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Assertions check the following on every cycle:
- A flag rises only after its own source pulse.
- After a read or a delayed write clear, the flags hold nothing older than the events of the clear cycle.
- A set-mode write leaves the chosen mask bits set.
- The summary rises only after a masked pending flag.
- The pin is high during any read.
- The pin falls only together with the summary or right after a read.

Some behaviour is only visible across several cycles, so the bench scenarios cover it. This includes the exact lag of bit 7 behind the flags, and the two-cycle delay of the write clear. It also includes events that were pending while masked and then show up after unmasking, and the single-cycle release of the pin under a source that fires every cycle.

// File: rtl/icr_pkg.sv
package icr_pkg;

  localparam int ICR_VIEW_W = 8;

  // Read view: summary on the top bit, flags packed from bit 0.
  function automatic logic [ICR_VIEW_W-1:0] icr_view(input logic sum,
                                                     input logic [ICR_VIEW_W-2:0] flags);
    return {sum, flags};
  endfunction

  // Set/clear mask update selected by the top data bit.
  function automatic logic [ICR_VIEW_W-2:0] mask_next(input logic [ICR_VIEW_W-2:0] cur,
                                                      input logic [ICR_VIEW_W-1:0] wdat);
    if (wdat[ICR_VIEW_W-1]) return cur | wdat[ICR_VIEW_W-2:0];
    return cur & ~wdat[ICR_VIEW_W-2:0];
  endfunction

  // True when some pending flag is enabled.
  function automatic logic any_enabled(input logic [ICR_VIEW_W-2:0] flags,
                                       input logic [ICR_VIEW_W-2:0] mask);
    return |(flags & mask);
  endfunction

endpackage

// File: rtl/icr_pending.sv
module icr_pending #(
  parameter int NSRC         = 5,
  parameter int WR_CLR_DELAY = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            rd_en,
  input  logic            wr_en,
  output logic [NSRC-1:0] flags_q,
  output logic            wr_clr_fire
);

  logic clear_now;

  generate
    if (WR_CLR_DELAY == 0) begin : g_wr_direct
      assign wr_clr_fire = wr_en;
    end else begin : g_wr_pipe
      logic [WR_CLR_DELAY-1:0] wr_pipe_q;
      always_ff @(posedge clk) begin
        if (!rst_n) wr_pipe_q <= '0;
        else if (WR_CLR_DELAY == 1) wr_pipe_q <= wr_en;
        else wr_pipe_q <= {wr_pipe_q[WR_CLR_DELAY-2:0], wr_en};
      end
      assign wr_clr_fire = wr_pipe_q[WR_CLR_DELAY-1];
    end
  endgenerate

  assign clear_now = rd_en | wr_clr_fire;

  // New events win over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (clear_now ? '0 : flags_q) | src_evt;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_flag_chk
      p_flag_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[gi]) |-> $past(src_evt[gi]));
    end
  endgenerate

  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((flags_q & ~$past(src_evt)) == '0));

  p_write_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_fire |=> ((flags_q & ~$past(src_evt)) == '0));

endmodule

// File: rtl/icr_mask.sv
module icr_mask
  import icr_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ICR_VIEW_W-1:0] wr_data,
  output logic [NSRC-1:0]       mask_q
);

  localparam int PAD = ICR_VIEW_W - 1 - NSRC;

  logic [ICR_VIEW_W-2:0] mask_wide;
  logic [ICR_VIEW_W-2:0] mask_upd;

  assign mask_wide = {{PAD{1'b0}}, mask_q};
  assign mask_upd  = mask_next(mask_wide, wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_upd[NSRC-1:0];
  end

  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[ICR_VIEW_W-1]) |=>
      ((mask_q & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0])));

  p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[ICR_VIEW_W-1]) |=> ((mask_q & $past(wr_data[NSRC-1:0])) == '0));

endmodule

// File: rtl/icr_summary.sv
module icr_summary
  import icr_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flags_q,
  input  logic [NSRC-1:0] mask_q,
  input  logic [NSRC-1:0] src_evt,
  input  logic            rd_en,
  output logic            masked_any,
  output logic            sum_q,
  output logic            req_q
);

  localparam int PAD = ICR_VIEW_W - 1 - NSRC;

  logic evt_enabled;

  assign masked_any  = any_enabled({{PAD{1'b0}}, flags_q}, {{PAD{1'b0}}, mask_q});
  assign evt_enabled = any_enabled({{PAD{1'b0}}, src_evt}, {{PAD{1'b0}}, mask_q});

  // Summary trails the flags by one cycle in both directions.
  always_ff @(posedge clk) begin
    if (!rst_n) sum_q <= 1'b0;
    else        sum_q <= masked_any;
  end

  // After a read only events of the read cycle may re-raise the request.
  always_ff @(posedge clk) begin
    if (!rst_n)     req_q <= 1'b0;
    else if (rd_en) req_q <= evt_enabled;
    else            req_q <= masked_any;
  end

  p_sum_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_q) |-> $past((flags_q & mask_q) != '0));

  p_sum_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sum_q) |-> $past((flags_q & mask_q) == '0));

endmodule

// File: rtl/icr_core.sv
module icr_core
  import icr_pkg::*;
#(
  parameter int NSRC         = 5,
  parameter int WR_CLR_DELAY = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       src_evt,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [ICR_VIEW_W-1:0] wr_data,
  output logic [ICR_VIEW_W-1:0] rd_data,
  output logic                  irq_n
);

  localparam int PAD = ICR_VIEW_W - 1 - NSRC;

  logic [NSRC-1:0] flags_q;
  logic [NSRC-1:0] mask_q;
  logic            wr_clr_fire;
  logic            masked_any;
  logic            sum_q;
  logic            req_q;

  icr_pending #(.NSRC(NSRC), .WR_CLR_DELAY(WR_CLR_DELAY)) u_pending (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .rd_en(rd_en), .wr_en(wr_en),
    .flags_q(flags_q), .wr_clr_fire(wr_clr_fire));

  icr_mask #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mask_q(mask_q));

  icr_summary #(.NSRC(NSRC)) u_summary (
    .clk(clk), .rst_n(rst_n), .flags_q(flags_q), .mask_q(mask_q), .src_evt(src_evt),
    .rd_en(rd_en), .masked_any(masked_any), .sum_q(sum_q), .req_q(req_q));

  assign rd_data = icr_view(sum_q, {{PAD{1'b0}}, flags_q});
  assign irq_n   = ~req_q | rd_en;

  always_comb begin
    p_read_release_r8: assert (!(rst_n && rd_en) || irq_n);
  end

  p_pin_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> (sum_q || $past(rd_en)));

  p_reset_idle_r10: assert property (@(posedge clk)
    $past(!rst_n) |-> (irq_n && rd_data == '0));

  p_pin_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !$past(rd_en)) |-> $past(masked_any));

endmodule

// File: tb/icr_core_test.sv
module icr_core_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_evt = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  icr_core uut (.clk(clk), .rst_n(rst_n), .src_evt(src_evt), .rd_en(rd_en),
                .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: plain integers, a two-entry list of write times.
  int m_flag, m_mask, m_sum, m_req;
  int wr_hist[$];

  always @(posedge clk) begin
    int en_any;
    int nf;
    if (!rst_n) begin
      m_flag = 0; m_mask = 0; m_sum = 0; m_req = 0;
      wr_hist = '{0, 0};
    end else begin
      en_any = ((m_flag & m_mask) != 0);
      nf = (rd_en || wr_hist[0] != 0) ? 0 : m_flag;
      nf = nf | src_evt;
      m_req = rd_en ? (((src_evt & m_mask) != 0) ? 1 : 0) : en_any;
      m_sum = en_any;
      if (wr_en) begin
        if (wr_data[7]) m_mask = m_mask | (wr_data & 8'h1f);
        else            m_mask = m_mask & ~(wr_data & 8'h1f);
      end
      void'(wr_hist.pop_front());
      wr_hist.push_back(wr_en ? 1 : 0);
      m_flag = nf;
    end
  end

  always begin
    @(negedge clk);
    #3;
    if (rst_n && !done) begin
      chk("R1 flags vs model", rd_data[4:0], m_flag);
      chk("R3 summary vs model", rd_data[7], m_sum);
      chk("R7 pin vs model", irq_n, rd_en ? 1 : (m_req ? 0 : 1));
    end
  end

  task automatic step(input bit r, input bit w, input logic [7:0] d, input logic [4:0] e);
    @(negedge clk);
    rd_en = r; wr_en = w; wr_data = d; src_evt = e;
    #2;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    chk("R10 reset view", rd_data, 8'h00);
    chk("R10 reset pin", irq_n, 1);

    // Enable timer A, let the delayed write clear pass.
    step(0, 1, 8'h81, 0);
    chk("R7 pin idle on write", irq_n, 1);
    repeat (3) step(0, 0, 0, 0);
    step(0, 0, 0, 5'h01);
    chk("R1 not yet latched", rd_data, 8'h00);
    step(0, 0, 0, 0);
    chk("R3 flag before summary", rd_data, 8'h01);
    chk("R7 pin waits for summary", irq_n, 1);
    step(0, 0, 0, 0);
    chk("R3 summary one cycle later", rd_data, 8'h81);
    chk("R7 pin asserted", irq_n, 0);
    step(1, 0, 0, 0);
    chk("R4 read shows old view", rd_data, 8'h81);
    chk("R8 pin released in read", irq_n, 1);
    step(0, 0, 0, 0);
    chk("R5 flags gone, summary lags", rd_data, 8'h80);
    chk("R8 pin stays released", irq_n, 1);
    step(0, 0, 0, 0);
    chk("R5 summary cleared", rd_data, 8'h00);

    // Masked timer B event is held, shown after unmask.
    step(0, 0, 0, 5'h02);
    step(0, 0, 0, 0);
    chk("R1 masked flag latched", rd_data, 8'h02);
    step(0, 0, 0, 0);
    chk("R3 masked flag no summary", rd_data, 8'h02);
    chk("R3 masked flag no pin", irq_n, 1);
    step(0, 1, 8'h82, 0);
    step(0, 0, 0, 0);
    chk("R6 flag kept after write", rd_data, 8'h02);
    step(0, 0, 0, 0);
    chk("R2 unmask reveals event", rd_data, 8'h82);
    chk("R2 unmask raises pin", irq_n, 0);
    step(0, 0, 0, 0);
    chk("R6 write clear third cycle", rd_data, 8'h80);
    step(0, 0, 0, 0);
    chk("R5 summary after write clear", rd_data, 8'h00);
    chk("R7 pin drops with summary", irq_n, 1);

    // Event arriving in the read cycle survives.
    step(1, 0, 0, 5'h04);
    step(0, 0, 0, 0);
    chk("R4 read-cycle event kept", rd_data, 8'h04);

    // Clear mask bits 0 and 1.
    step(0, 1, 8'h03, 0);
    step(0, 0, 0, 0);
    chk("R6 flag one after write", rd_data, 8'h04);
    step(0, 0, 0, 0);
    chk("R6 flag two after write", rd_data, 8'h04);
    step(0, 0, 0, 0);
    chk("R6 cleared three after write", rd_data, 8'h00);
    step(0, 0, 0, 5'h01);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R2 cleared mask blocks summary", rd_data, 8'h01);
    chk("R2 cleared mask blocks pin", irq_n, 1);

    // Serial and flag bits, enabled, one source every cycle on timer A.
    step(0, 1, 8'h99, 0);
    repeat (3) step(0, 0, 0, 0);
    step(0, 0, 0, 5'h18);
    step(0, 0, 0, 0);
    chk("R1 serial and flag bits", rd_data, 8'h18);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 5'h01);
    chk("R9 pin low under constant source", irq_n, 0);
    step(1, 0, 0, 5'h01);
    chk("R9 pin high in read", irq_n, 1);
    chk("R9 summary stays set", rd_data[7], 1);
    step(0, 0, 0, 5'h01);
    chk("R9 pin back next cycle", irq_n, 0);
    chk("R9 summary still set", rd_data, 8'h81);
    step(1, 0, 0, 0);
    repeat (3) step(0, 0, 0, 0);
    chk("R5 all quiet", rd_data, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule